// File: doc/BRIEF.md
# Radio Time-Code Frame Decoder

This block turns the demodulated carrier of a longwave time-signal receiver into calendar fields. The carrier is reduced for a short pulse at the start of every second. A short pulse carries a 0 and a long pulse carries a 1. In the last second of each minute the pulse is left out, and that longer silence marks the start of a new minute. The raw carrier is brought into the clock domain and debounced. The block then times the spacing between edges in units of a 1 ms tick enable. It slices every pulse into a data bit and keeps up to 59 bits per minute.

When the minute gap arrives, the block checks the collected frame. The frame must hold exactly 59 bits. The three even-parity groups must agree, the start bit must be 0 and the fixed bit at position 20 must be 1. If all of this holds, the block decodes the minute, hour, day of month, weekday, month and year. Each field uses weights 1, 2, 4, 8, 10, 20, 40, 80 from its least significant bit. The fields are presented together with a one-clock valid strobe. Any other frame ends in a one-clock error strobe, and the previous fields stay on the outputs.

Top module: `tcode_frame_dec`

## Requirements
- R1: While reset is high, and on the first cycle after it, the valid and error strobes are 0 and every field output is 0.
- R2: A level change on the carrier that lasts fewer than DEBOUNCE_TICKS ticks has no effect on the decoded frame.
- R3: A pulse (carrier high) lasting at least ONE_MIN_TICKS ticks is stored as a 1, and a shorter pulse is stored as a 0. Bits are stored at increasing positions starting from 0.
- R4: A low gap before a rising edge is a minute marker only if its length is strictly greater than MARK_LO_TICKS and strictly less than MARK_HI_TICKS. Gaps of exactly either bound are not markers.
- R5: The fields are decoded least significant bit first, with weights 1, 2, 4, 8, 10, 20, 40, 80. Each field has a start position and a width: minute 21/7, hour 29/6, day 36/6, weekday 42/3, month 45/5, year 50/8.
- R6: frame_valid_o pulses for exactly one clock at a marker only when exactly 59 bits were stored, all parity checks pass, bit 0 is 0 and bit 20 is 1.
- R7: At any marker that does not meet R6, frame_err_o pulses for one clock instead. A frame with 58 bits, a failed parity, bit 0 = 1 or bit 20 = 0 counts as a failure, and so does the first marker after reset when no bits have been stored.
- R8: When more than 59 bits arrive without a marker, the bit position stops at 59, the extra bits are dropped and the next marker reports an error. The following frame then decodes normally.
- R9: The field outputs change only in the cycle in which frame_valid_o is high. After an error they keep the last good values.
- R10: frame_valid_o and frame_err_o are never high together. Parity is even over positions 21..28 (minute), 29..35 (hour) and 36..58 (date).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms_i | input | 1 | One-cycle enable, once per millisecond |
| carrier_i | input | 1 | Demodulated carrier, high during a pulse, asynchronous |
| frame_valid_o | output | 1 | One-cycle strobe: new fields accepted |
| frame_err_o | output | 1 | One-cycle strobe: frame rejected at a marker |
| minute_o | output | 7 | Decoded minute |
| hour_o | output | 6 | Decoded hour |
| mday_o | output | 6 | Decoded day of month |
| wday_o | output | 3 | Decoded weekday |
| month_o | output | 5 | Decoded month |
| year_o | output | 7 | Decoded two-digit year |

## Verification
The assertions assume that minute markers are spaced well apart and that a rising and a falling carrier edge never reach the timer in the same cycle. This holds whenever every pulse and gap is at least the debounce length. The bench keeps the tick enable high on every clock and scales the timing parameters down to tens of ticks. Every pulse and gap it drives is a whole number of clocks and longer than the debounce window. The only exception is a deliberate two-cycle glitch, which the filter must absorb, so the measured intervals are exact and the boundary lengths can be hit to the tick.

// File: rtl/tcode_pkg.sv
package tcode_pkg;

  // Frame layout: positions are fixed by the broadcast format
  localparam int START_POS = 0;
  localparam int FIXED_POS = 20;
  localparam int MIN_LSB   = 21;
  localparam int MIN_W     = 7;
  localparam int MIN_PAR   = 28;
  localparam int HOUR_LSB  = 29;
  localparam int HOUR_W    = 6;
  localparam int HOUR_PAR  = 35;
  localparam int MDAY_LSB  = 36;
  localparam int MDAY_W    = 6;
  localparam int WDAY_LSB  = 42;
  localparam int WDAY_W    = 3;
  localparam int MON_LSB   = 45;
  localparam int MON_W     = 5;
  localparam int YEAR_LSB  = 50;
  localparam int YEAR_W    = 8;
  localparam int DATE_PAR  = 58;

  typedef struct packed {
    logic [6:0] minute;
    logic [5:0] hour;
    logic [5:0] mday;
    logic [2:0] wday;
    logic [4:0] month;
    logic [6:0] year;
  } tcode_fields_t;

  // weight of bit j inside a two-digit BCD field
  function automatic logic [7:0] digit_weight(input int j);
    if (j < 4) return 8'(1 << j);
    else       return 8'(10 << (j - 4));
  endfunction

  function automatic logic [7:0] bcd_weighted(input logic [7:0] bits, input int len);
    logic [7:0] acc;
    acc = '0;
    for (int j = 0; j < 8; j++) begin
      if (j < len && bits[j]) acc = acc + digit_weight(j);
    end
    return acc;
  endfunction

endpackage

// File: rtl/tcode_deglitch.sv
module tcode_deglitch #(
  parameter int DB_TICKS = 20,
  localparam int DB_W = $clog2(DB_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic            sync_a, sync_b;
  logic            level, level_d;
  logic [DB_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a   <= 1'b0;
      sync_b   <= 1'b0;
      level    <= 1'b0;
      level_d  <= 1'b0;
      hold_cnt <= '0;
    end else begin
      sync_a  <= din;
      sync_b  <= sync_a;
      level_d <= level;
      if (sync_b == level) begin
        hold_cnt <= '0;
      end else if (tick) begin
        if (hold_cnt == DB_W'(DB_TICKS - 1)) begin
          level    <= sync_b;
          hold_cnt <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end

  assign rise = level & ~level_d;
  assign fall = ~level & level_d;

endmodule

// File: rtl/tcode_pulse_timer.sv
module tcode_pulse_timer #(
  parameter int CNT_W         = 12,
  parameter int ONE_MIN_TICKS = 200,
  parameter int MARK_LO_TICKS = 1000,
  parameter int MARK_HI_TICKS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rise,
  input  logic fall,
  output logic bit_we,
  output logic bit_val,
  output logic marker
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] span;
  logic [CNT_W:0]   span_sum;
  logic [CNT_W-1:0] span_now;

  // length including the tick of the current cycle, saturating
  assign span_sum = {1'b0, span} + {{CNT_W{1'b0}}, tick};
  assign span_now = span_sum[CNT_W] ? CNT_MAX : span_sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      span    <= '0;
      bit_we  <= 1'b0;
      bit_val <= 1'b0;
      marker  <= 1'b0;
    end else begin
      bit_we  <= fall;
      bit_val <= span_now >= CNT_W'(ONE_MIN_TICKS);
      marker  <= rise && (span_now > CNT_W'(MARK_LO_TICKS))
                      && (span_now < CNT_W'(MARK_HI_TICKS));
      if (rise || fall)                 span <= '0;
      else if (tick && span != CNT_MAX) span <= span + 1'b1;
    end
  end

endmodule

// File: rtl/tcode_frame_asm.sv
module tcode_frame_asm
  import tcode_pkg::*;
#(
  parameter int FRAME_BITS = 59,
  localparam int IDX_W = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_we,
  input  logic          bit_val,
  input  logic          marker,
  output logic          valid,
  output logic          err,
  output tcode_fields_t fields,
  output logic [IDX_W-1:0] bit_idx
);

  logic [FRAME_BITS-1:0] bits_q;
  logic                  overrun;
  logic                  parity_ok, frame_ok;
  tcode_fields_t         decoded;

  // bit storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (bit_we && bit_idx < IDX_W'(FRAME_BITS)) bits_q[bit_idx] <= bit_val;
  end

  assign parity_ok = ~(^bits_q[MIN_PAR:MIN_LSB])
                   & ~(^bits_q[HOUR_PAR:HOUR_LSB])
                   & ~(^bits_q[DATE_PAR:MDAY_LSB]);

  assign frame_ok = (bit_idx == IDX_W'(FRAME_BITS)) && !overrun && parity_ok
                  && !bits_q[START_POS] && bits_q[FIXED_POS];

  always_comb begin
    logic [7:0] v_min, v_hour, v_mday, v_wday, v_mon, v_year;
    v_min  = bcd_weighted({1'b0, bits_q[MIN_LSB +: MIN_W]}, MIN_W);
    v_hour = bcd_weighted({2'b0, bits_q[HOUR_LSB +: HOUR_W]}, HOUR_W);
    v_mday = bcd_weighted({2'b0, bits_q[MDAY_LSB +: MDAY_W]}, MDAY_W);
    v_wday = bcd_weighted({5'b0, bits_q[WDAY_LSB +: WDAY_W]}, WDAY_W);
    v_mon  = bcd_weighted({3'b0, bits_q[MON_LSB +: MON_W]}, MON_W);
    v_year = bcd_weighted(bits_q[YEAR_LSB +: YEAR_W], YEAR_W);
    decoded.minute = v_min[6:0];
    decoded.hour   = v_hour[5:0];
    decoded.mday   = v_mday[5:0];
    decoded.wday   = v_wday[2:0];
    decoded.month  = v_mon[4:0];
    decoded.year   = v_year[6:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
      overrun <= 1'b0;
      valid   <= 1'b0;
      err     <= 1'b0;
      fields  <= '0;
    end else begin
      valid <= 1'b0;
      err   <= 1'b0;
      if (marker) begin
        valid   <= frame_ok;
        err     <= !frame_ok;
        if (frame_ok) fields <= decoded;
        bit_idx <= '0;
        overrun <= 1'b0;
      end else if (bit_we) begin
        if (bit_idx < IDX_W'(FRAME_BITS)) bit_idx <= bit_idx + 1'b1;
        else                              overrun <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tcode_frame_dec.sv
module tcode_frame_dec
  import tcode_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 20,
  parameter int ONE_MIN_TICKS  = 200,
  parameter int MARK_LO_TICKS  = 1000,
  parameter int MARK_HI_TICKS  = 2000,
  parameter int CNT_W          = 12,
  parameter int FRAME_BITS     = 59,
  localparam int IDX_W = $clog2(FRAME_BITS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms_i,
  input  logic       carrier_i,
  output logic       frame_valid_o,
  output logic       frame_err_o,
  output logic [6:0] minute_o,
  output logic [5:0] hour_o,
  output logic [5:0] mday_o,
  output logic [2:0] wday_o,
  output logic [4:0] month_o,
  output logic [6:0] year_o
);

  logic             edge_rise, edge_fall;
  logic             bit_we, bit_val, marker;
  logic [IDX_W-1:0] bit_idx;
  tcode_fields_t    fields;

  tcode_deglitch #(.DB_TICKS(DEBOUNCE_TICKS)) u_deglitch (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_ms_i),
    .din  (carrier_i),
    .rise (edge_rise),
    .fall (edge_fall)
  );

  tcode_pulse_timer #(
    .CNT_W        (CNT_W),
    .ONE_MIN_TICKS(ONE_MIN_TICKS),
    .MARK_LO_TICKS(MARK_LO_TICKS),
    .MARK_HI_TICKS(MARK_HI_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_ms_i),
    .rise   (edge_rise),
    .fall   (edge_fall),
    .bit_we (bit_we),
    .bit_val(bit_val),
    .marker (marker)
  );

  tcode_frame_asm #(.FRAME_BITS(FRAME_BITS)) u_asm (
    .clk    (clk),
    .rst    (rst),
    .bit_we (bit_we),
    .bit_val(bit_val),
    .marker (marker),
    .valid  (frame_valid_o),
    .err    (frame_err_o),
    .fields (fields),
    .bit_idx(bit_idx)
  );

  assign minute_o = fields.minute;
  assign hour_o   = fields.hour;
  assign mday_o   = fields.mday;
  assign wday_o   = fields.wday;
  assign month_o  = fields.month;
  assign year_o   = fields.year;

endmodule

// File: rtl/tcode_frame_dec_chk.sv
module tcode_frame_dec_chk #(
  parameter int FRAME_BITS = 59,
  localparam int IDX_W = $clog2(FRAME_BITS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_valid_o,
  input logic             frame_err_o,
  input logic [6:0]       minute_o,
  input logic [5:0]       hour_o,
  input logic [5:0]       mday_o,
  input logic [2:0]       wday_o,
  input logic [4:0]       month_o,
  input logic [6:0]       year_o,
  input logic [IDX_W-1:0] bit_idx,
  input logic             bit_we,
  input logic             marker
);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!frame_valid_o && !frame_err_o && minute_o == 7'd0 && year_o == 7'd0));

  // R10
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(frame_valid_o && frame_err_o));

  // R6
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |=> !frame_valid_o);

  // R7
  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);

  // R6
  a_r6_full_count: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> $past(bit_idx) == IDX_W'(FRAME_BITS));

  // R8
  a_r8_idx_saturates: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= IDX_W'(FRAME_BITS));

  // R4
  a_r4_marker_not_bit: assert property (@(posedge clk) disable iff (rst)
    !(bit_we && marker));

  // R9
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_valid_o |-> $stable({minute_o, hour_o, mday_o, wday_o, month_o, year_o}));

endmodule

bind tcode_frame_dec tcode_frame_dec_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (.*);

// File: tb/tcode_frame_dec_tb.sv
module tcode_frame_dec_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DB   = 3;
  localparam int ONE  = 20;
  localparam int LO   = 100;
  localparam int HI   = 200;
  localparam int SEC  = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms_i = 1'b1;
  logic       carrier_i = 1'b0;
  logic       frame_valid_o, frame_err_o;
  logic [6:0] minute_o, year_o;
  logic [5:0] hour_o, mday_o;
  logic [2:0] wday_o;
  logic [4:0] month_o;

  int n_cmp = 0;
  int n_bad = 0;
  int n_valid = 0;
  int n_err = 0;
  int g_min = 0, g_hour = 0, g_mday = 0, g_wday = 0, g_mon = 0, g_year = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcode_frame_dec #(
    .DEBOUNCE_TICKS(DB), .ONE_MIN_TICKS(ONE), .MARK_LO_TICKS(LO),
    .MARK_HI_TICKS(HI), .CNT_W(9), .FRAME_BITS(59)
  ) u_dut (.*);

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_valid_o) n_valid++;
      if (frame_err_o)   n_err++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [58:0] build(input int mi, input int hr, input int dd,
                                        input int wd, input int mo, input int yr);
    logic [58:0] f;
    logic [7:0]  t;
    f = '0;
    for (int i = 1; i < 20; i++) f[i] = (i % 3 == 1);
    f[20] = 1'b1;
    t = to_bcd(mi); f[27:21] = t[6:0]; f[28] = ^f[27:21];
    t = to_bcd(hr); f[34:29] = t[5:0]; f[35] = ^f[34:29];
    t = to_bcd(dd); f[41:36] = t[5:0];
    f[44:42] = 3'(wd);
    t = to_bcd(mo); f[49:45] = t[4:0];
    f[57:50] = to_bcd(yr);
    f[58] = ^f[57:36];
    return f;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic second(input logic b, input int zw, input int ow, input int extra, input bit glitch);
    int w;
    w = b ? ow : zw;
    carrier_i = 1'b1;
    wait_clk(w);
    carrier_i = 1'b0;
    if (glitch) begin
      wait_clk(30);
      carrier_i = 1'b1;
      wait_clk(2);
      carrier_i = 1'b0;
      wait_clk(SEC - w + extra - 32);
    end else begin
      wait_clk(SEC - w + extra);
    end
  endtask

  // closes the running frame and sends bit 0 of the next one
  task automatic mark(input int w0);
    carrier_i = 1'b1;
    wait_clk(w0);
    carrier_i = 1'b0;
    wait_clk(SEC - w0);
  endtask

  // bits 1..nbits-1, last gap tuned to 'gap' ticks, then the closing edge
  task automatic frame(input logic [58:0] f, input int zw, input int ow, input int nbits,
                       input int gap, input int next_w0, input bit glitch);
    int last_w;
    n_valid = 0;
    n_err   = 0;
    last_w  = f[nbits-1] ? ow : zw;
    for (int i = 1; i < nbits; i++)
      second(f[i], zw, ow, (i == nbits - 1) ? gap - (SEC - last_w) : 0, glitch && i == 5);
    mark(next_w0);
  endtask

  task automatic check_fields(input string req);
    check({req, " minute"},  int'(minute_o), g_min);
    check({req, " hour"},    int'(hour_o),   g_hour);
    check({req, " mday"},    int'(mday_o),   g_mday);
    check({req, " wday"},    int'(wday_o),   g_wday);
    check({req, " month"},   int'(month_o),  g_mon);
    check({req, " year"},    int'(year_o),   g_year);
  endtask

  task automatic good_frame(input int k, input int zw, input int ow, input int gap, input bit glitch, input string tag);
    int mi, hr, dd, wd, mo, yr;
    mi = (k * 17 + 3) % 60;  hr = (k * 7 + 5) % 24;  dd = 1 + (k * 11) % 31;
    wd = 1 + k % 7;          mo = 1 + (k * 5) % 12;   yr = (k * 13 + 9) % 100;
    frame(build(mi, hr, dd, wd, mo, yr), zw, ow, 59, gap, 10, glitch);
    g_min = mi; g_hour = hr; g_mday = dd; g_wday = wd; g_mon = mo; g_year = yr;
    check({tag, " R6 valid count"}, n_valid, 1);
    check({tag, " R7 err count"},   n_err, 0);
    check_fields({tag, " R5"});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [58:0] f;
    wait_clk(5);
    check("R1 valid in reset", int'(frame_valid_o), 0);
    rst = 1'b0;
    wait_clk(1);
    check("R1 valid after reset", int'(frame_valid_o), 0);
    check("R1 err after reset", int'(frame_err_o), 0);
    check_fields("R1");

    // first marker with no bits stored
    n_err = 0;
    wait_clk(140);
    mark(10);
    check("R7 empty frame err", n_err, 1);
    check("R7 empty frame valid", n_valid, 0);

    // sweep of good frames: widths, boundary gaps, glitch
    for (int k = 0; k < 8; k++) begin
      int zw, ow, gap;
      zw  = (k % 2 == 1) ? ONE - 1 : 10;   // R3 boundary 19 vs 20
      ow  = ONE;
      if (k == 3) begin zw = 5; ow = 25; end
      gap = 185;
      if (k == 4) gap = LO + 1;             // R4 lower side
      if (k == 5) gap = HI - 1;             // R4 upper side
      good_frame(k, zw, ow, gap, k == 6, (k == 6) ? "R2 glitch" : "R3 R4 sweep");
    end

    // minute parity broken
    f = build(12, 13, 14, 5, 6, 27);
    f[21] = ~f[21];
    frame(f, 10, 20, 59, 185, 10, 1'b0);
    check("R7 parity err", n_err, 1);
    check("R10 parity valid", n_valid, 0);
    check_fields("R9 after parity err");

    // fixed bit 20 cleared, closing pulse makes next bit 0 a 1
    f = build(12, 13, 14, 5, 6, 27);
    f[20] = 1'b0;
    frame(f, 10, 20, 59, 185, 20, 1'b0);
    check("R7 bit20 err", n_err, 1);
    check("R7 bit20 valid", n_valid, 0);

    f = build(40, 20, 30, 7, 11, 98);
    frame(f, 10, 20, 59, 185, 10, 1'b0);
    check("R7 bit0 err", n_err, 1);
    check("R7 bit0 valid", n_valid, 0);
    check_fields("R9 after bit0 err");

    // one bit short
    frame(build(1, 2, 3, 4, 5, 6), 10, 20, 58, 185, 10, 1'b0);
    check("R7 short err", n_err, 1);
    check("R7 short valid", n_valid, 0);

    // gap equal to upper bound is no marker, then overrun
    frame(build(1, 2, 3, 4, 5, 6), 10, 20, 59, HI, 10, 1'b0);
    check("R4 gap=HI no err", n_err, 0);
    check("R4 gap=HI no valid", n_valid, 0);
    frame(build(2, 3, 4, 5, 6, 7), 10, 20, 59, 185, 10, 1'b0);
    check("R8 overrun err", n_err, 1);
    check("R8 overrun valid", n_valid, 0);
    check_fields("R9 after overrun");
    good_frame(9, 10, 20, 185, 1'b0, "R8 recovery");

    // gap equal to lower bound is no marker either
    frame(build(1, 2, 3, 4, 5, 6), 10, 20, 59, LO, 10, 1'b0);
    check("R4 gap=LO no err", n_err, 0);
    check("R4 gap=LO no valid", n_valid, 0);
    frame(build(2, 3, 4, 5, 6, 7), 10, 20, 59, 185, 10, 1'b0);
    check("R8 overrun err 2", n_err, 1);
    good_frame(10, 10, 20, 185, 1'b0, "R10 final");

    summary();
    $finish;
  end

endmodule